// File: doc/BRIEF.md
# Amplitude Scaling and Dither Stage

This stage sits between a sine lookup table and a DAC. Every valid sample is a signed amplitude word. The stage multiplies it by an unsigned gain held in a programmable register and rounds the product back to table width. It then reduces the word to the narrower DAC width. Before that reduction it can add a small pseudo-random offset of about half an output LSB. The offset breaks up the periodic pattern of the quantization error that otherwise limits the spur-free range.

The dither source is a free-running maximal-length shift register inside the block. It advances once per sample, so the sequence of dither values depends only on how many samples have been processed. The result saturates to the DAC range. A build parameter selects two's-complement or offset-binary output coding.

Top module: `amDitherStage`

## Requirements
- R1: While reset is asserted and after its release with no input, `outValid` is 0 and `outData` is 0.
- R2: The gain register resets to 0x8000, which is unity gain: with dither off, a sample x produces `floor((x + 8) / 16)` on the default 16-to-12-bit widths.
- R3: The scaled word is `floor((x * gain + 2^14) / 2^15)`, where gain is unsigned and x is signed. It is clamped to the signed 16-bit range [-32768, 32767].
- R4: With dither off for a sample, the output is `floor((scaled + 8) / 16)` and no noise is added.
- R5: With dither on for a sample, the signed 4-bit value d taken from shift-register bits [22:19] is added first, giving `floor((scaled + d + 8) / 16)`. The value d lies in [-8, 7], which spans ±½ output LSB.
- R6: The dither register is 23 bits wide and reset to 0x4D2A1F. Each step shifts left, and bit 0 takes the XOR of bits 22 and 17. It steps exactly once per sample, whether or not dither is enabled, and it never holds zero.
- R7: The dithered result is clamped to the signed 12-bit range [-2048, 2047] and does not wrap.
- R8: A gain write takes effect for samples that arrive in later cycles. A sample that arrives in the same cycle as the write uses the previous gain. The gain register changes only on a write.
- R9: `outValid` rises exactly two cycles after each accepted input sample. Back-to-back samples give back-to-back outputs, and no output appears without an input.
- R10: With the offset-binary parameter set, the output equals the two's-complement result with bit 11 inverted.
- R11: The dither enable is captured together with each sample, so a change of the enable affects only the samples accepted with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample present this cycle |
| inData | input | 16 | Signed amplitude from the sine table |
| gainWe | input | 1 | Gain register write strobe |
| gainData | input | 16 | Unsigned gain value, 0x8000 is unity |
| ditherEn | input | 1 | Add dither to this sample |
| outValid | output | 1 | DAC code present this cycle |
| outData | output | 12 | DAC code |

## Verification
Each sample passes through one multiply register and one output register. Its code is therefore due on the second rising edge after the edge that accepts it. A gain write becomes visible one edge after its strobe. When the bench drives a sample, it records the edge count at which the output is due. A monitor then samples on the falling edge of exactly that cycle. Any `outValid` outside a recorded slot counts as a failure. The expected codes come from an integer model of the multiply, rounding and clamps, together with an independent copy of the shift-register recurrence stepped once per driven sample.

// File: rtl/amDitherPkg.sv
package amDitherPkg;
  typedef struct packed {
    logic loadScale;
    logic loadOut;
    logic addDither;
  } stageStrobes_t;
endpackage

// File: rtl/amDitherCtrl.sv
module amDitherCtrl
  import amDitherPkg::*;
#(
  parameter int GAIN_W = 16,
  parameter int DW = 4,
  parameter int LFSR_W = 23,
  parameter int LFSR_TAP = 18,
  parameter logic [LFSR_W-1:0] SEED = 23'h4D2A1F,
  parameter logic [GAIN_W-1:0] GAIN_RESET = 16'h8000
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic ditherEn,
  input  logic gainWe,
  input  logic [GAIN_W-1:0] gainData,
  output stageStrobes_t strobes,
  output logic [GAIN_W-1:0] gainReg,
  output logic signed [DW-1:0] ditherVal,
  output logic [LFSR_W-1:0] lfsrState,
  output logic outValid
);
  logic valid1;
  logic dither1;
  logic [LFSR_W-1:0] lfsrNext;

  assign lfsrNext = {lfsrState[LFSR_W-2:0],
                     lfsrState[LFSR_W-1] ^ lfsrState[LFSR_TAP-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid1    <= 1'b0;
      dither1   <= 1'b0;
      outValid  <= 1'b0;
      gainReg   <= GAIN_RESET;
      lfsrState <= SEED;
    end else begin
      valid1   <= inValid;
      dither1  <= inValid & ditherEn;
      outValid <= valid1;
      if (gainWe) gainReg <= gainData;
      if (valid1) lfsrState <= lfsrNext;
    end
  end

  always_comb begin
    strobes.loadScale = inValid;
    strobes.loadOut   = valid1;
    strobes.addDither = dither1;
  end

  assign ditherVal = lfsrState[LFSR_W-1 -: DW];
endmodule

// File: rtl/amDitherPath.sv
module amDitherPath
  import amDitherPkg::*;
#(
  parameter int IN_W = 16,
  parameter int GAIN_W = 16,
  parameter int OUT_W = 12,
  parameter bit OFFSET_BINARY = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  stageStrobes_t strobes,
  input  logic signed [IN_W-1:0] inData,
  input  logic [GAIN_W-1:0] gainReg,
  input  logic signed [IN_W-OUT_W-1:0] ditherVal,
  output logic [OUT_W-1:0] outData
);
  localparam int DW = IN_W - OUT_W;
  localparam int PW = IN_W + GAIN_W + 1;
  localparam int SW = IN_W + 2;
  localparam logic signed [PW-1:0] ROUND1 = PW'(2 ** (GAIN_W - 2));
  localparam logic signed [PW-1:0] MAX1 = PW'(2 ** (IN_W - 1) - 1);
  localparam logic signed [PW-1:0] MIN1 = -PW'(2 ** (IN_W - 1));
  localparam logic signed [SW-1:0] HALF2 = SW'(2 ** (DW - 1));
  localparam logic signed [SW-1:0] MAX2 = SW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [SW-1:0] MIN2 = -SW'(2 ** (OUT_W - 1));

  logic signed [PW-1:0] dataExt, gainExt, product, rounded;
  logic signed [IN_W-1:0] scaledNext, scaled;
  logic signed [DW-1:0] ditherUsed;
  logic signed [SW-1:0] sum2, quot2;
  logic [OUT_W-1:0] twosWord, outWord;

  // stage 1: gain multiply, round to table width, clamp
  always_comb begin
    dataExt = {{(PW-IN_W){inData[IN_W-1]}}, inData};
    gainExt = {{(PW-GAIN_W){1'b0}}, gainReg};
    product = dataExt * gainExt;
    rounded = (product + ROUND1) >>> (GAIN_W - 1);
    if (rounded > MAX1)      scaledNext = MAX1[IN_W-1:0];
    else if (rounded < MIN1) scaledNext = MIN1[IN_W-1:0];
    else                     scaledNext = rounded[IN_W-1:0];
  end

  // stage 2: dither, reduce to output width, clamp
  always_comb begin
    ditherUsed = strobes.addDither ? ditherVal : '0;
    sum2 = {{(SW-IN_W){scaled[IN_W-1]}}, scaled}
         + {{(SW-DW){ditherUsed[DW-1]}}, ditherUsed} + HALF2;
    quot2 = sum2 >>> DW;
    if (quot2 > MAX2)      twosWord = MAX2[OUT_W-1:0];
    else if (quot2 < MIN2) twosWord = MIN2[OUT_W-1:0];
    else                   twosWord = quot2[OUT_W-1:0];
  end

  generate
    if (OFFSET_BINARY) begin : g_offsetBin
      assign outWord = {~twosWord[OUT_W-1], twosWord[OUT_W-2:0]};
    end else begin : g_twosComp
      assign outWord = twosWord;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scaled  <= '0;
      outData <= '0;
    end else begin
      if (strobes.loadScale) scaled <= scaledNext;
      if (strobes.loadOut)   outData <= outWord;
    end
  end
endmodule

// File: rtl/amDitherStage.sv
module amDitherStage
  import amDitherPkg::*;
#(
  parameter int IN_W = 16,
  parameter int GAIN_W = 16,
  parameter int OUT_W = 12,
  parameter int LFSR_W = 23,
  parameter int LFSR_TAP = 18,
  parameter logic [LFSR_W-1:0] SEED = 23'h4D2A1F,
  parameter bit OFFSET_BINARY = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [IN_W-1:0] inData,
  input  logic gainWe,
  input  logic [GAIN_W-1:0] gainData,
  input  logic ditherEn,
  output logic outValid,
  output logic [OUT_W-1:0] outData
);
  localparam int DW = IN_W - OUT_W;
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(2 ** (GAIN_W - 1));

  stageStrobes_t strobes;
  logic [GAIN_W-1:0] gainReg;
  logic signed [DW-1:0] ditherVal;
  logic [LFSR_W-1:0] lfsrState;

  amDitherCtrl #(
    .GAIN_W(GAIN_W), .DW(DW), .LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP),
    .SEED(SEED), .GAIN_RESET(UNITY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ditherEn(ditherEn),
    .gainWe(gainWe), .gainData(gainData), .strobes(strobes),
    .gainReg(gainReg), .ditherVal(ditherVal), .lfsrState(lfsrState),
    .outValid(outValid)
  );

  amDitherPath #(
    .IN_W(IN_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .OFFSET_BINARY(OFFSET_BINARY)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .gainReg(gainReg), .ditherVal(ditherVal), .outData(outData)
  );
endmodule

// File: rtl/amDitherStage_chk.sv
module amDitherStage_chk #(
  parameter int GAIN_W = 16,
  parameter int LFSR_W = 23
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic outValid,
  input logic gainWe,
  input logic [GAIN_W-1:0] gainData,
  input logic [GAIN_W-1:0] gainReg,
  input logic [LFSR_W-1:0] lfsrState
);
  AST_OUT_DUE: assert property (@(posedge clk) disable iff (!rstN) inValid |-> ##2 outValid); // R9
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rstN) outValid |-> $past(inValid, 2)); // R9
  AST_GAIN_LOAD: assert property (@(posedge clk) disable iff (!rstN) gainWe |=> gainReg == $past(gainData)); // R8
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN) !gainWe |=> $stable(gainReg)); // R8
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rstN) lfsrState != '0); // R6
  AST_LFSR_STEP: assert property (@(posedge clk) disable iff (!rstN) outValid |-> !$stable(lfsrState)); // R6
  AST_LFSR_IDLE: assert property (@(posedge clk) disable iff (!rstN) !outValid |-> $stable(lfsrState)); // R6
endmodule

bind amDitherStage amDitherStage_chk #(.GAIN_W(GAIN_W), .LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .gainWe(gainWe), .gainData(gainData), .gainReg(gainReg), .lfsrState(lfsrState)
);

// File: tb/amDitherStage_tb.sv
module amDitherStage_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] inData = '0;
  logic gainWe = 1'b0;
  logic [15:0] gainData = '0;
  logic ditherEn = 1'b0;
  logic outValid, outValidOb;
  logic [11:0] outData, outDataOb;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int modelGain = 32768;
  int modelLfsr = 32'h4D2A1F;
  int qDue[$];
  int qExp[$];
  string qTag[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  amDitherStage u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .gainWe(gainWe), .gainData(gainData), .ditherEn(ditherEn),
    .outValid(outValid), .outData(outData)
  );

  amDitherStage #(.OFFSET_BINARY(1'b1)) u_dutOb (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .gainWe(gainWe), .gainData(gainData), .ditherEn(ditherEn),
    .outValid(outValidOb), .outData(outDataOb)
  );

  task automatic check(string tag, int actual, int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  function automatic int modelCode(int x, int g, int d);
    longint p, r, t;
    p = longint'(x) * longint'(g);
    r = (p + 16384) >>> 15;               // R3
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    t = (r + d + 8) >>> 4;                // R4 R5
    if (t > 2047) t = 2047;               // R7
    if (t < -2048) t = -2048;
    return int'(t) & 32'hFFF;
  endfunction

  // drive one cycle; a sample is predicted with the gain in force before any write this cycle
  task automatic drive(bit v, int x, bit en, bit we, int g, string tag);
    int d;
    @(negedge clk);
    inValid = v; inData = 16'(x); ditherEn = en; gainWe = we; gainData = 16'(g);
    if (v) begin
      d = (modelLfsr >> 19) & 15;
      if (d >= 8) d -= 16;
      qDue.push_back(cyc + 2);
      qExp.push_back(modelCode(x, modelGain, en ? d : 0));
      qTag.push_back(tag);
      modelLfsr = ((modelLfsr << 1) | (((modelLfsr >> 22) ^ (modelLfsr >> 17)) & 1)) & 32'h7FFFFF; // R6
    end
    if (we) modelGain = g;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 1'b0, 1'b0, 0, "");
  endtask

  task automatic sample(int x, bit en, string tag);
    drive(1'b1, x, en, 1'b0, 0, tag);
    idle(3);
  endtask

  task automatic writeGain(int g);
    drive(1'b0, 0, 1'b0, 1'b1, g, "");
    idle(1);
  endtask

  // monitor: each recorded output is checked in its due cycle, nothing else may appear
  always @(negedge clk) begin
    if (rstN) begin
      if (qDue.size() > 0 && qDue[0] == cyc) begin
        check({qTag[0], " R9 valid"}, int'(outValid), 1);
        check(qTag[0], int'(outData), qExp[0]);
        check({qTag[0], " R10 offset"}, int'(outDataOb), qExp[0] ^ 32'h800);
        void'(qDue.pop_front()); void'(qExp.pop_front()); void'(qTag.pop_front());
      end else if (outValid || outValidOb) begin
        check("R9 unexpected output", int'(outValid | outValidOb), 0);
      end
    end
  end

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(outValid), 0);
    check("R1 data in reset", int'(outData), 0);
    @(negedge clk); rstN = 1'b1;
    idle(3);
    check("R1 valid after reset", int'(outValid), 0);
    check("R1 data after reset", int'(outData), 0);
  endtask

  task automatic testUnity();
    sample(1600, 1'b0, "R2 unity 1600");
    sample(-1600, 1'b0, "R2 unity -1600");
    sample(7, 1'b0, "R4 round 7");
    sample(8, 1'b0, "R4 round 8");
    sample(-8, 1'b0, "R4 round -8");
    sample(-9, 1'b0, "R4 round -9");
  endtask

  task automatic testGain();
    writeGain(16'h4000);
    sample(20000, 1'b0, "R3 half gain");
    writeGain(16'hC000);
    sample(-12345, 1'b0, "R3 gain 1.5");
    writeGain(16'h0001);
    sample(16384, 1'b0, "R3 tiny gain rounding");
    writeGain(16'h0000);
    sample(-32768, 1'b0, "R3 zero gain");
  endtask

  task automatic testSaturation();
    writeGain(16'hFFFF);
    sample(32767, 1'b1, "R7 positive clamp");
    sample(-32768, 1'b1, "R7 negative clamp");
    writeGain(16'h8000);
    sample(32767, 1'b1, "R7 top with dither");
  endtask

  task automatic testDither();
    for (int i = 0; i < 12; i++) sample(300 * i - 1700, 1'b1, "R5 dither on");
    sample(100, 1'b0, "R6 lfsr steps while off");
    sample(100, 1'b1, "R6 lfsr after off");
  endtask

  task automatic testStream();
    for (int i = 0; i < 16; i++)
      drive(1'b1, 1000 * i - 7000, 1'(i % 3 == 0), 1'b0, 0, "R11 stream enable toggling");
    idle(4);
  endtask

  task automatic testGainTiming();
    drive(1'b1, 9000, 1'b0, 1'b1, 16'h2000, "R8 same-cycle old gain");
    drive(1'b1, 9000, 1'b0, 1'b0, 0, "R8 next sample new gain");
    idle(4);
    writeGain(16'h8000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    testReset();
    testUnity();
    testGain();
    testSaturation();
    testDither();
    testStream();
    testGainTiming();
    idle(4);
    check("R9 all outputs delivered", qDue.size(), 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule